// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer for a chip's control bus, reached through a simple 16-bit register interface with byte enables. Software writes a timeout in ticks, clears the halt bit to start counting, and then writes the reload register at intervals to keep the system alive. A prescaler derives the tick from the system clock, and the tick period is set by a parameter. The counter counts down from the stored initial value.

When the count runs out for the first time, the block sets a timeout flag, reloads the counter and keeps counting. The flag can drive an interrupt line. If the count runs out again before software clears that flag, the block records a second-timeout flag and pulses a reset request. A no-reboot control bit can block that request. A third-stage flag marks a repeated second-stage expiry. All status flags are cleared by writing 1 to them.

Top module: `twostage_wdt`

## Requirements
- R1: Register offsets (byte addresses on `bus_addr`) are: 0x00 reload and live count, 0x04 first status, 0x06 second status, 0x08 control, 0x0C interrupt enable, 0x12 initial value. After reset the control register reads 0x0801, with halt in bit 11 and no-reboot in bit 0. Both status registers read 0. The live count and the initial value both read the INIT_RST parameter, 0x03FF by default.
- R2: The initial value field at 0x12 is 10 bits wide, in bits 9:0. Bits 15:10 are plain storage that reads back what was written. `bus_be[0]` enables bits 7:0 and `bus_be[1]` enables bits 15:8. A write whose merged 10-bit value is below 4 is ignored as a whole.
- R3: A write of any data to 0x00 with any byte enable loads the counter from the initial value. A read of 0x00 returns the live count in bits 9:0, with bits 15:10 reading zero.
- R4: While halt is 0, a tick occurs once every TICK_DIV clock cycles and the count drops by one per tick. When halt goes from 1 to 0 at edge E, ticks fall on edges E+k·TICK_DIV. While halt is 1 the count holds and the prescaler is held at zero.
- R5: A tick that arrives with the count at 0 is an expiry. The expiry sets first-status bit 3 and reloads the counter, so each stage lasts exactly (initial value + 1) ticks.
- R6: An expiry while first-status bit 3 is already set also sets second-status bit 1. Unless no-reboot is set, it also drives `rst_req_o` high for exactly the one cycle after that edge.
- R7: While no-reboot (control bit 0) is 1, `rst_req_o` stays low. The second-stage status is still recorded.
- R8: A second-stage expiry while second-status bit 1 is already set also sets second-status bit 2.
- R9: Status bits 0x04 bit 3, 0x06 bit 1 and 0x06 bit 2 are cleared by writing 1 to them. Writing 0 leaves them unchanged. If an expiry sets a bit in the same cycle as a clear, the set wins.
- R10: `irq_o` is high exactly while first-status bit 3 is set and interrupt-enable bit 13 at 0x0C is 1. The enable bit resets to 0.
- R11: A reload write that lands on a tick edge takes priority. That tick neither decrements the counter nor expires, and the tick phase is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_be | input | 2 | Byte enables for the write data |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| irq_o | output | 1 | Level interrupt on first-stage timeout |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
Register writes take effect at the clock edge that samples the strobe, and reads are combinational, so a read made in the low phase after that edge already sees the new value. Tick-driven results are due at a computed edge. With halt released at edge E, the first expiry shows in the status after edge E+(N+1)·TICK_DIV and the second after E+2(N+1)·TICK_DIV, with the reset pulse visible only in the cycle after that edge. The bench keeps its own edge counter, waits for the edge one before and the edge exactly at each due point, and samples both in the low phase of the clock. This shows that the result does not arrive early and does arrive on time. For random reload patterns the bench finds the first tick after the last reload from the tick phase and computes the expiry edge from it.

// File: rtl/twostage_wdt.sv
`timescale 1ns/1ps
module twostage_wdt #(
  parameter int               TICK_DIV = 12_000_000,
  parameter int               CNT_W    = 10,
  parameter int               DW       = 16,
  parameter int               AW       = 5,
  parameter logic [CNT_W-1:0] INIT_RST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [1:0]    bus_be,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o,
  output logic          rst_req_o
);
  localparam int PRE_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int SPARE_W = DW - CNT_W;
  localparam int MIN_INIT = 4;
  localparam logic [AW-1:0] A_RLD = AW'(8'h00);
  localparam logic [AW-1:0] A_ST1 = AW'(8'h04);
  localparam logic [AW-1:0] A_ST2 = AW'(8'h06);
  localparam logic [AW-1:0] A_CTL = AW'(8'h08);
  localparam logic [AW-1:0] A_IEN = AW'(8'h0C);
  localparam logic [AW-1:0] A_INI = AW'(8'h12);

  logic [PRE_W-1:0]   pre_q;
  logic [CNT_W-1:0]   cnt_q, init_q;
  logic [SPARE_W-1:0] spare_q;
  logic halt_q, noreboot_q, irq_en_q;
  logic to_sts_q, sec_sts_q, boot_sts_q, rst_q;

  logic [DW-1:0] wmask, clr, init_word, init_new;
  logic wr_rld, wr_st1, wr_st2, wr_ctl, wr_ien, wr_ini, tick, expire;

  assign wmask  = {{(DW-8){bus_be[1]}}, {8{bus_be[0]}}};
  assign clr    = bus_wdata & wmask;
  assign wr_rld = bus_wr && (bus_addr == A_RLD) && (|bus_be);
  assign wr_st1 = bus_wr && (bus_addr == A_ST1);
  assign wr_st2 = bus_wr && (bus_addr == A_ST2);
  assign wr_ctl = bus_wr && (bus_addr == A_CTL);
  assign wr_ien = bus_wr && (bus_addr == A_IEN);
  assign wr_ini = bus_wr && (bus_addr == A_INI);

  assign init_word = {spare_q, init_q};
  assign init_new  = (init_word & ~wmask) | (bus_wdata & wmask);

  assign tick   = !halt_q && (pre_q == PRE_W'(TICK_DIV - 1));
  assign expire = tick && !wr_rld && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               pre_q <= '0;
    else if (halt_q || tick)                  pre_q <= '0;
    else                                      pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= INIT_RST;
    else if (wr_rld)  cnt_q <= init_q;
    else if (tick)    cnt_q <= (cnt_q == '0) ? init_q : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q  <= INIT_RST;
      spare_q <= '0;
    end else if (wr_ini && (init_new[CNT_W-1:0] >= CNT_W'(MIN_INIT))) begin
      init_q  <= init_new[CNT_W-1:0];
      spare_q <= init_new[DW-1:CNT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q     <= 1'b1;
      noreboot_q <= 1'b1;
      irq_en_q   <= 1'b0;
    end else begin
      if (wr_ctl && bus_be[1]) halt_q     <= bus_wdata[11];
      if (wr_ctl && bus_be[0]) noreboot_q <= bus_wdata[0];
      if (wr_ien && bus_be[1]) irq_en_q   <= bus_wdata[13];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_sts_q   <= 1'b0;
      sec_sts_q  <= 1'b0;
      boot_sts_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      if (expire)                   to_sts_q <= 1'b1;
      else if (wr_st1 && clr[3])    to_sts_q <= 1'b0;
      if (expire && to_sts_q)       sec_sts_q <= 1'b1;
      else if (wr_st2 && clr[1])    sec_sts_q <= 1'b0;
      if (expire && to_sts_q && sec_sts_q) boot_sts_q <= 1'b1;
      else if (wr_st2 && clr[2])    boot_sts_q <= 1'b0;
      rst_q <= expire && to_sts_q && !noreboot_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_RLD: bus_rdata[CNT_W-1:0] = cnt_q;
      A_ST1: bus_rdata[3] = to_sts_q;
      A_ST2: begin
        bus_rdata[1] = sec_sts_q;
        bus_rdata[2] = boot_sts_q;
      end
      A_CTL: begin
        bus_rdata[11] = halt_q;
        bus_rdata[0]  = noreboot_q;
      end
      A_IEN: bus_rdata[13] = irq_en_q;
      A_INI: bus_rdata = init_word;
      default: bus_rdata = '0;
    endcase
  end

  assign irq_o     = to_sts_q && irq_en_q;
  assign rst_req_o = rst_q;
endmodule

// File: rtl/twostage_wdt_chk.sv
`timescale 1ns/1ps
module twostage_wdt_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] init_q,
  input logic             halt_q,
  input logic             wr_rld,
  input logic             to_sts_q,
  input logic             sec_sts_q,
  input logic             rst_req_o
);
  assert_rst_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  assert_rst_needs_sec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> sec_sts_q);

  assert_sec_after_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_sts_q) |-> $past(to_sts_q));

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rld |=> (cnt_q == $past(init_q)));

  assert_halt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !wr_rld) |=> $stable(cnt_q));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_rld |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - 1'b1) ||
                 (($past(cnt_q) == '0) && (cnt_q == $past(init_q)))));

  assert_first_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_sts_q) |-> ($past(cnt_q) == '0));

  assert_init_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init_q >= CNT_W'(4));
endmodule

bind twostage_wdt twostage_wdt_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .init_q(init_q), .halt_q(halt_q),
  .wr_rld(wr_rld), .to_sts_q(to_sts_q), .sec_sts_q(sec_sts_q), .rst_req_o(rst_req_o));

// File: tb/twostage_wdt_tb_top.sv
`timescale 1ns/1ps
module twostage_wdt_tb_top;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_o, rst_req_o;

  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  twostage_wdt #(.TICK_DIV(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .rst_req_o(rst_req_o));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic [1:0] be);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  function automatic int expiry_edge(input int es, input int last, input int n);
    return es + D * ((last - es) / D + 1) + D * n;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int e0, e1, e2, es, last, n, k, gap, ex;
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1 ctrl", 5'h08, 16'h0801);
    rd_chk("R1 sts1", 5'h04, 16'h0000);
    rd_chk("R1 sts2", 5'h06, 16'h0000);
    rd_chk("R1 count", 5'h00, 16'h03FF);
    rd_chk("R1 init", 5'h12, 16'h03FF);
    chk("R1 irq", {15'd0, irq_o}, 16'h0000);
    chk("R1 rst", {15'd0, rst_req_o}, 16'h0000);

    // R2 init field
    wr(5'h12, 16'h0003, 2'b11);
    rd_chk("R2 small ignored", 5'h12, 16'h03FF);
    wr(5'h12, 16'hFC05, 2'b11);
    rd_chk("R2 full write", 5'h12, 16'hFC05);
    wr(5'h12, 16'h0002, 2'b11);
    rd_chk("R2 small ignored whole", 5'h12, 16'hFC05);
    wr(5'h12, 16'h0007, 2'b01);
    rd_chk("R2 low byte only", 5'h12, 16'hFC07);

    // R3 reload while halted, R4 halt holds
    wr(5'h00, 16'h0000, 2'b01);
    rd_chk("R3 reload live count", 5'h00, 16'h0007);
    repeat (40) @(negedge clk);
    rd_chk("R4 halted holds", 5'h00, 16'h0007);

    // R5 first expiry, N=7
    wr(5'h08, 16'h0001, 2'b11);
    e0 = cyc;
    wait_until(e0 + 4);
    rd_chk("R4 one tick", 5'h00, 16'h0006);
    wait_until(e0 + 31);
    rd_chk("R5 count at zero", 5'h00, 16'h0000);
    rd_chk("R5 not yet expired", 5'h04, 16'h0000);
    wait_until(e0 + 32);
    rd_chk("R5 first status", 5'h04, 16'h0008);
    rd_chk("R5 reloaded", 5'h00, 16'h0007);
    chk("R10 irq disabled", {15'd0, irq_o}, 16'h0000);
    wr(5'h0C, 16'h2000, 2'b10);
    chk("R10 irq enabled", {15'd0, irq_o}, 16'h0001);

    // R7 second expiry with no-reboot
    wait_until(e0 + 63);
    rd_chk("R6 second not yet", 5'h06, 16'h0000);
    wait_until(e0 + 64);
    rd_chk("R7 second recorded", 5'h06, 16'h0002);
    chk("R7 rst blocked", {15'd0, rst_req_o}, 16'h0000);

    // R9 write-one-to-clear
    wr(5'h04, 16'h0000, 2'b11);
    rd_chk("R9 zero no effect", 5'h04, 16'h0008);
    wr(5'h04, 16'h0008, 2'b11);
    rd_chk("R9 clear sts1", 5'h04, 16'h0000);
    chk("R10 irq follows status", {15'd0, irq_o}, 16'h0000);
    wr(5'h06, 16'h0002, 2'b01);
    rd_chk("R9 clear sts2", 5'h06, 16'h0000);

    // R6 reset pulse, R8 third stage
    wr(5'h08, 16'h0800, 2'b11);
    wr(5'h00, 16'h0000, 2'b11);
    wr(5'h08, 16'h0000, 2'b11);
    e1 = cyc;
    wait_until(e1 + 63);
    chk("R6 rst early", {15'd0, rst_req_o}, 16'h0000);
    wait_until(e1 + 64);
    chk("R6 rst pulse", {15'd0, rst_req_o}, 16'h0001);
    rd_chk("R6 second status", 5'h06, 16'h0002);
    wait_until(e1 + 65);
    chk("R6 rst one cycle", {15'd0, rst_req_o}, 16'h0000);
    wait_until(e1 + 96);
    rd_chk("R8 boot status", 5'h06, 16'h0006);
    chk("R6 rst again", {15'd0, rst_req_o}, 16'h0001);
    wr(5'h06, 16'h0006, 2'b11);
    rd_chk("R9 clear both sts2", 5'h06, 16'h0000);

    // R11 reload on a tick edge
    wr(5'h08, 16'h0801, 2'b11);
    wr(5'h04, 16'h0008, 2'b11);
    wr(5'h00, 16'h0000, 2'b11);
    wr(5'h08, 16'h0001, 2'b11);
    e2 = cyc;
    wait_until(e2 + 3);
    wr(5'h00, 16'h0000, 2'b11);
    rd_chk("R11 tick overridden", 5'h00, 16'h0007);
    wait_until(e2 + 8);
    rd_chk("R11 phase kept", 5'h00, 16'h0006);

    // random reload patterns
    for (int it = 0; it < 20; it++) begin
      wr(5'h08, 16'h0801, 2'b11);
      wr(5'h04, 16'h0008, 2'b11);
      n = 4 + int'($urandom % 20);
      wr(5'h12, 16'(n), 2'b11);
      wr(5'h00, 16'h0000, 2'b11);
      wr(5'h08, 16'h0001, 2'b11);
      es = cyc;
      last = es;
      k = 1 + int'($urandom % 4);
      for (int p = 0; p < k; p++) begin
        gap = 1 + int'($urandom % (D * n));
        wait_until(last + gap - 1);
        wr(5'h00, 16'h0000, 2'b11);
        last = cyc;
      end
      ex = expiry_edge(es, last, n);
      wait_until(ex - 1);
      rd_chk("R5 random no early expiry", 5'h04, 16'h0000);
      wait_until(ex);
      rd_chk("R5 random expiry", 5'h04, 16'h0008);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule